// File: doc/BRIEF.md
# Receive Buffer Flush and Wake Controller

This block decides when data sitting in a receive buffer is handed to the host side as one packet. On every host IN-request pulse it checks three flush causes: a full packet's worth of data, an expired latency timer, or a pending forced flush. If any cause holds, it raises a one-cycle send flag and gives the packet length. Otherwise the request goes unanswered, and the host retries later. The latency timer is set in whole milliseconds (1 to 255). It counts only while the buffer holds data and starts again after every sent packet.

A single active-low strobe pin has two uses, chosen by the link state. While the link is active, a falling edge arms one forced flush. The next IN request then sends whatever is buffered, even a short or empty packet. While the link is suspended, a falling edge asks the bus to resume by means of a fixed-length pulse, but only if remote wakeup is enabled. Otherwise the edge is dropped.

The send flag is a valid-only output. The IN request acts as the ready side, and no back-pressure exists beyond it. A consumer must take the length in the cycle the flag is high. Control and status pins are plain levels.

Top module: `rxq_flush_wake`

## Requirements
- R1: During and after reset, `send_now` and `resume_req` are 0 and `pkt_len` is 0.
- R2: An IN request while `fill_level` is at least PKT_BYTES (64) raises `send_now` for one cycle in the next cycle, with `pkt_len` = PKT_BYTES, whatever the timer or the strobe are doing.
- R3: An IN request while 0 < `fill_level` < PKT_BYTES, with no expired timer and no armed flush, gives no `send_now`.
- R4: Once the buffer has been non-empty for `latency_ms` × TICKS_PER_MS cycles without a send, the next IN request sends `pkt_len` = `fill_level` (capped at PKT_BYTES). An IN request well before that time sends nothing.
- R5: The latency timer restarts from zero after every sent packet and stays at zero while `fill_level` is 0. A `latency_ms` value of 0 acts as 1.
- R6: A falling edge on `strobe_n` while `suspended` = 0 arms exactly one flush. The next IN request sends min(`fill_level`, PKT_BYTES). A later IN request with no new edge does not send again.
- R7: An IN request with a flush armed and `fill_level` = 0 raises `send_now` with `pkt_len` = 0 (a zero-length packet).
- R8: A falling edge on `strobe_n` while `suspended` = 1 and `wake_en` = 1 raises `resume_req` within 4 cycles, for exactly WAKE_CYC (6) consecutive cycles. It does not arm a flush.
- R9: A falling edge on `strobe_n` while `suspended` = 1 and `wake_en` = 0 is ignored. No `resume_req` appears, and no flush is armed for after the suspend ends.
- R10: `send_now` is only ever high in the cycle after an IN request, and `pkt_len` never exceeds PKT_BYTES or the fill level seen at that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_level | input | LVL_W (9) | Bytes currently held in the receive buffer |
| latency_ms | input | LAT_W (8) | Latency timeout in milliseconds, 1..255 (0 acts as 1) |
| in_req | input | 1 | One-cycle host IN-request pulse |
| suspended | input | 1 | Link is in suspend |
| wake_en | input | 1 | Remote wakeup allowed |
| strobe_n | input | 1 | Asynchronous active-low flush/wake strobe |
| send_now | output | 1 | One-cycle flag: send a packet now |
| pkt_len | output | LEN_W (7) | Packet length, valid while send_now is high |
| resume_req | output | 1 | Fixed-length resume request pulse |

## Verification
The bench goes after the timer boundary. It asks just before and just after the programmed time, and a timer that counts the wrong number of ticks or does not restart after a send would answer either the early request or the repeat request. It also holds the strobe low across two IN requests, where a level-sensitive design would send twice instead of once, and it forces a flush on an empty buffer, where a design that skips zero-length packets would stay silent. Strobes while suspended are tried with wakeup both on and off. A design that mixed up the two uses of the pin would either leave a flush armed for after the suspend or raise a resume when it must not, and a miscounted pulse shows up as a wrong width.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_FULL  = 2'd1,
    CAUSE_TIMER = 2'd2,
    CAUSE_FORCE = 2'd3
  } flush_cause_e;
endpackage

// File: rtl/rxq_strobe_sync.sv
module rxq_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fell
);
  // pin_n enters at bit 0; bits 1..STAGES-1 finish synchronising;
  // bit STAGES holds the previous synchronised value for edge detection.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], pin_n};
  end

  assign fell = sh[STAGES] & ~sh[STAGES-1];

  a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fell |=> !fell);
endmodule

// File: rtl/rxq_lat_timer.sv
module rxq_lat_timer #(
  parameter int TICKS_PER_MS = 48000,
  parameter int LAT_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [LAT_W-1:0] lat_ms,
  output logic             expired
);
  localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [LAT_W-1:0] ms_q;
  logic [LAT_W-1:0] lat_eff;
  logic             ms_tick;

  assign lat_eff = (lat_ms == '0) ? LAT_W'(1) : lat_ms;
  assign ms_tick = (pre_q == PRE_W'(TICKS_PER_MS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pre_q   <= '0;
      ms_q    <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (ms_tick) begin
        pre_q <= '0;
        if (ms_q + LAT_W'(1) >= lat_eff) expired <= 1'b1;
        else                              ms_q    <= ms_q + LAT_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  a_r5_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clear) |=> expired);
endmodule

// File: rtl/rxq_resume_pulse.sv
module rxq_resume_pulse #(
  parameter int WAKE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (trig && cnt_q == '0)  cnt_q <= CNT_W'(WAKE_CYC);
    else if (cnt_q != '0)          cnt_q <= cnt_q - CNT_W'(1);
  end

  assign pulse = (cnt_q != '0);

  a_r8_start_on_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(trig));
endmodule

// File: rtl/rxq_flush_wake.sv
module rxq_flush_wake
  import rxq_pkg::*;
#(
  parameter int BUF_DEPTH    = 256,
  parameter int PKT_BYTES    = 64,
  parameter int TICKS_PER_MS = 48000,
  parameter int LAT_W        = 8,
  parameter int WAKE_CYC     = 6,
  parameter int SYNC_STAGES  = 2,
  localparam int LVL_W       = $clog2(BUF_DEPTH + 1),
  localparam int LEN_W       = $clog2(PKT_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [LAT_W-1:0] latency_ms,
  input  logic             in_req,
  input  logic             suspended,
  input  logic             wake_en,
  input  logic             strobe_n,
  output logic             send_now,
  output logic [LEN_W-1:0] pkt_len,
  output logic             resume_req
);
  logic         strobe_fell;
  logic         tmo;
  logic         force_q;
  logic         is_full;
  logic         is_empty;
  logic         fire;
  logic         wake_trig;
  flush_cause_e cause;

  rxq_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (strobe_n),
    .fell  (strobe_fell)
  );

  assign is_full  = (fill_level >= LVL_W'(PKT_BYTES));
  assign is_empty = (fill_level == '0);

  // Cause priority: a full packet wins, then the timer, then the strobe.
  always_comb begin
    cause = CAUSE_NONE;
    if (in_req) begin
      if (is_full)      cause = CAUSE_FULL;
      else if (tmo)     cause = CAUSE_TIMER;
      else if (force_q) cause = CAUSE_FORCE;
    end
  end

  assign fire = (cause != CAUSE_NONE);

  rxq_lat_timer #(.TICKS_PER_MS(TICKS_PER_MS), .LAT_W(LAT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (fire || is_empty),
    .lat_ms  (latency_ms),
    .expired (tmo)
  );

  // A new edge arms a flush even in the cycle an older one is consumed.
  always_ff @(posedge clk) begin
    if (!rst_n)                       force_q <= 1'b0;
    else if (strobe_fell && !suspended) force_q <= 1'b1;
    else if (fire)                    force_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_now <= 1'b0;
      pkt_len  <= '0;
    end else begin
      send_now <= fire;
      if (fire)
        pkt_len <= (cause == CAUSE_FULL) ? LEN_W'(PKT_BYTES)
                                         : fill_level[LEN_W-1:0];
    end
  end

  assign wake_trig = strobe_fell && suspended && wake_en;

  rxq_resume_pulse #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (wake_trig),
    .pulse (resume_req)
  );

  a_r10_send_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    send_now |-> $past(in_req));
  a_r2_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    (send_now && $past(is_full)) |-> (pkt_len == LEN_W'(PKT_BYTES)));
  a_r10_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    send_now |-> (pkt_len <= LEN_W'(PKT_BYTES)
                  && LVL_W'(pkt_len) <= $past(fill_level)));
  a_r9_wake_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_req) |-> $past(suspended && wake_en));
endmodule

// File: tb/rxq_flush_wake_tb_top.sv
module rxq_flush_wake_tb_top;
  localparam int PKT   = 64;
  localparam int TICKS = 20;
  localparam int WAKE  = 6;
  localparam int LVL_W = 9;
  localparam int LEN_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LVL_W-1:0] fill_level = '0;
  logic [7:0]       latency_ms = 8'd200;
  logic             in_req = 1'b0;
  logic             suspended = 1'b0;
  logic             wake_en = 1'b0;
  logic             strobe_n = 1'b1;
  logic             send_now;
  logic [LEN_W-1:0] pkt_len;
  logic             resume_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rxq_flush_wake #(
    .BUF_DEPTH(256), .PKT_BYTES(PKT), .TICKS_PER_MS(TICKS),
    .LAT_W(8), .WAKE_CYC(WAKE), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .fill_level(fill_level), .latency_ms(latency_ms),
    .in_req(in_req), .suspended(suspended), .wake_en(wake_en),
    .strobe_n(strobe_n), .send_now(send_now), .pkt_len(pkt_len),
    .resume_req(resume_req)
  );

  function automatic int exp_len(int fill);
    return (fill > PKT) ? PKT : fill;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pulse in_req for one cycle; return what the block answered.
  task automatic ask(output int s, output int len);
    in_req = 1'b1;
    @(negedge clk);
    in_req = 1'b0;
    s = send_now;
    len = pkt_len;
  endtask

  task automatic empty_buf();
    fill_level = '0;
    wait_cyc(2);
  endtask

  task automatic strobe_edge();
    strobe_n = 1'b0;
    wait_cyc(5);
    strobe_n = 1'b1;
    wait_cyc(3);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int s, len, cnt, f, first;
    void'($urandom(32'd2718));
    @(negedge clk);
    check("R1 send_now in reset", send_now, 0);
    check("R1 resume_req in reset", resume_req, 0);
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 send_now after reset", send_now, 0);
    check("R1 pkt_len after reset", pkt_len, 0);
    check("R1 resume_req after reset", resume_req, 0);

    // R2 and R3 under random fill levels
    for (int i = 0; i < 30; i++) begin
      empty_buf();
      if ($urandom_range(0, 1) == 1) begin
        f = $urandom_range(PKT, 256);
        fill_level = LVL_W'(f);
        wait_cyc(2);
        ask(s, len);
        check("R2 full send", s, 1);
        check("R2 full len", len, PKT);
      end else begin
        f = $urandom_range(1, PKT - 1);
        fill_level = LVL_W'(f);
        wait_cyc(2);
        ask(s, len);
        check("R3 partial no send", s, 0);
      end
    end

    // R4 timer boundary, R5 restart
    latency_ms = 8'd3;
    empty_buf();
    fill_level = 9'd10;
    wait_cyc(3 * TICKS - 8);
    ask(s, len);
    check("R4 early no send", s, 0);
    wait_cyc(12);
    ask(s, len);
    check("R4 timeout send", s, 1);
    check("R4 timeout len", len, 10);
    ask(s, len);
    check("R5 restart no repeat", s, 0);
    wait_cyc(3 * TICKS + 4);
    ask(s, len);
    check("R5 second timeout", s, 1);
    latency_ms = 8'd0;
    empty_buf();
    fill_level = 9'd7;
    wait_cyc(TICKS + 4);
    ask(s, len);
    check("R5 zero latency acts as one", s, 1);
    check("R5 zero latency len", len, 7);
    // empty buffer holds the timer at zero
    latency_ms = 8'd2;
    empty_buf();
    wait_cyc(3 * TICKS);
    fill_level = 9'd5;
    wait_cyc(3);
    ask(s, len);
    check("R5 no count while empty", s, 0);
    latency_ms = 8'd200;

    // R6 forced flush under random fills, one per edge
    for (int i = 0; i < 12; i++) begin
      empty_buf();
      f = $urandom_range(1, 200);
      fill_level = LVL_W'(f);
      strobe_edge();
      ask(s, len);
      check("R6 forced send", s, 1);
      check("R6 forced len", len, exp_len(f));
      if (f < PKT) begin
        ask(s, len);
        check("R6 one flush per edge", s, 0);
      end
    end
    // strobe held low across two requests
    empty_buf();
    fill_level = 9'd20;
    strobe_n = 1'b0;
    wait_cyc(5);
    ask(s, len);
    check("R6 held low first", s, 1);
    ask(s, len);
    check("R6 held low no second", s, 0);
    strobe_n = 1'b1;
    wait_cyc(3);

    // R7 zero-length packet
    empty_buf();
    strobe_edge();
    ask(s, len);
    check("R7 zlp send", s, 1);
    check("R7 zlp len", len, 0);

    // R8 resume with wakeup enabled
    suspended = 1'b1;
    wake_en = 1'b1;
    fill_level = 9'd12;
    wait_cyc(2);
    strobe_n = 1'b0;
    cnt = 0;
    first = -1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (resume_req) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    strobe_n = 1'b1;
    check("R8 resume width", cnt, WAKE);
    check("R8 resume start within 4", (first >= 0 && first < 4) ? 1 : 0, 1);
    suspended = 1'b0;
    wait_cyc(3);
    ask(s, len);
    check("R8 no flush armed by wake", s, 0);

    // R9 wakeup disabled: ignored entirely
    suspended = 1'b1;
    wake_en = 1'b0;
    wait_cyc(2);
    strobe_n = 1'b0;
    cnt = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (resume_req) cnt++;
    end
    strobe_n = 1'b1;
    check("R9 no resume", cnt, 0);
    suspended = 1'b0;
    wait_cyc(3);
    ask(s, len);
    check("R9 no flush armed", s, 0);

    // R10 no send without a request
    cnt = 0;
    fill_level = 9'd100;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (send_now) cnt++;
    end
    check("R10 idle no send", cnt, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule